// File: doc/BRIEF.md
# Rotate-Right Execution Unit

This unit is a purely combinational decode-and-execute slice for right rotations. It reads a 32-bit instruction word together with the values of its two source registers, and returns the destination register index, the rotated value and a write-enable. The rotates reuse the function codes of the logical right shifts. A spare five-bit field holding the value 00001 marks the instruction as a rotate rather than a shift.

Five forms are recognised:
- A 32-bit rotate by an immediate amount.
- A 32-bit rotate by an amount held in a register.
- A 64-bit rotate by an immediate amount.
- A 64-bit rotate by the immediate plus 32.
- A 64-bit rotate by an amount held in a register.

When the word is a shift encoding without the marker, the unit drops its valid output. A separate shift unit then takes the instruction.

Top module: `rotr_unit`

## Requirements
- R1: With instr[31:26]=000000, instr[25:21]=00001 and instr[5:0]=000010, the low 32 bits of rt_val are rotated right by instr[10:6].
- R2: With instr[31:26]=000000, instr[10:6]=00001 and instr[5:0]=000110, the low 32 bits of rt_val are rotated right by rs_val[4:0]. Higher bits of rs_val have no effect.
- R3: With instr[31:26]=000000, instr[25:21]=00001 and instr[5:0]=111010, rt_val is rotated right by instr[10:6] over all 64 bits.
- R4: With instr[31:26]=000000, instr[25:21]=00001 and instr[5:0]=111110, rt_val is rotated right by instr[10:6]+32 over all 64 bits.
- R5: With instr[31:26]=000000, instr[10:6]=00001 and instr[5:0]=010110, rt_val is rotated right by rs_val[5:0]. Higher bits of rs_val have no effect.
- R6: In the two 32-bit forms, rt_val[63:32] has no effect, and result[63:32] copies bit 31 of the rotated word.
- R7: An effective rotate amount of zero returns the operand unchanged. In the 32-bit forms the operand is sign-extended.
- R8: For a shift function code whose marker field (instr[25:21] for the immediate forms, instr[10:6] for the variable forms) is not 00001, rot_valid=0, wr_en=0 and result=0.
- R9: A word with instr[31:26] other than 000000, or with a function code outside the five listed, gives rot_valid=0, wr_en=0 and result=0.
- R10: dst_idx always equals instr[15:11]. wr_en is 1 only for a valid rotate whose destination index is not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs_val | input | 64 | Value of the register named by instr[25:21] |
| rt_val | input | 64 | Value of the register named by instr[20:16] (operand) |
| rot_valid | output | 1 | Word is a recognised rotate |
| wr_en | output | 1 | Write result to register dst_idx |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Rotated value, zero when not a rotate |

## Verification
The operand has distinct nibbles, so a rotate by the wrong amount or in the wrong direction gives a visibly different result. Amounts of 4, 8 and 16 each move whole digits, so every rotation is easy to tell apart. The 32-bit cases cover a rotated word whose top bit is set and one whose top bit is clear, which separates sign extension from zero extension. They also use operands with garbage in the upper half, which exposes any leak of rt_val[63:32].

Register-amount cases set bits above the mask width, so that a wrong mask width changes the result. The immediate-plus-32 form is driven with amounts 0, 4 and 31. Near-miss words check that the unit rejects them:
- the marker cleared or altered;
- a nonzero opcode;
- a neighbouring arithmetic-shift function code;
- destination register zero.

// File: rtl/rotr_unit.sv
module rotr_unit #(
  parameter int          XLEN = 64,
  parameter logic [4:0]  MARK = 5'b00001
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            rot_valid,
  output logic            wr_en,
  output logic [4:0]      dst_idx,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);
  localparam int SHH  = $clog2(HALF);

  typedef enum logic [2:0] {K_NONE, K_IMM32, K_VAR32, K_IMM64, K_HI64, K_VAR64} kind_t;

  wire [5:0] op = instr[31:26];
  wire [5:0] fn = instr[5:0];
  wire [4:0] fs = instr[25:21];
  wire [4:0] sa = instr[10:6];
  wire       unused_bits = ^{rs_val[XLEN-1:SHW], instr[20:16]};

  kind_t          kind;
  logic [SHW-1:0] amt;

  always_comb begin
    kind = K_NONE;
    if (op == 6'b000000) begin
      case (fn)
        6'b000010: if (fs == MARK) kind = K_IMM32;
        6'b000110: if (sa == MARK) kind = K_VAR32;
        6'b111010: if (fs == MARK) kind = K_IMM64;
        6'b111110: if (fs == MARK) kind = K_HI64;
        6'b010110: if (sa == MARK) kind = K_VAR64;
        default:   kind = K_NONE;
      endcase
    end
  end

  always_comb begin
    case (kind)
      K_IMM32: amt = SHW'(sa);
      K_VAR32: amt = SHW'(rs_val[SHH-1:0]);
      K_IMM64: amt = SHW'(sa);
      K_HI64:  amt = SHW'(sa) + SHW'(HALF);
      K_VAR64: amt = rs_val[SHW-1:0];
      default: amt = '0;
    endcase
  end

  wire              is32  = (kind == K_IMM32) || (kind == K_VAR32);
  wire [HALF-1:0]   lo    = rt_val[HALF-1:0];
  wire [XLEN-1:0]   dbl32 = {lo, lo} >> amt[SHH-1:0];
  wire [2*XLEN-1:0] dbl64 = {rt_val, rt_val} >> amt;
  wire [HALF-1:0]   r32   = dbl32[HALF-1:0];
  wire [XLEN-1:0]   r64   = dbl64[XLEN-1:0];

  assign rot_valid = (kind != K_NONE);
  assign dst_idx   = instr[15:11];
  assign wr_en     = rot_valid && (dst_idx != 5'd0);
  assign result    = !rot_valid ? '0 :
                     is32       ? {{HALF{r32[HALF-1]}}, r32} : r64;
endmodule

// File: rtl/rotr_unit_chk.sv
module rotr_unit_chk #(
  parameter int XLEN = 64
) (
  input logic [31:0]     instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic            rot_valid,
  input logic            wr_en,
  input logic [4:0]      dst_idx,
  input logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;
  wire [5:0] fn = instr[5:0];
  wire       unused_rs = ^rs_val;

  always_comb begin
    a_r8_idle_zero: assert (rot_valid || (!wr_en && result == '0))
      else $error("R8: inactive unit drives output");
    a_r10_no_zero_write: assert (!wr_en || (rot_valid && dst_idx != 5'd0))
      else $error("R10: bad write enable");
    a_r9_opcode: assert (instr[31:26] == 6'b000000 || !rot_valid)
      else $error("R9: nonzero opcode accepted");
    if (rot_valid && (fn == 6'b000010 || fn == 6'b000110)) begin
      a_r6_sext: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})
        else $error("R6: upper half not sign copy");
    end
    if (rot_valid && fn == 6'b111010 && instr[10:6] == 5'd0) begin
      a_r7_zero_amt: assert (result == rt_val)
        else $error("R7: zero rotate changed operand");
    end
  end
endmodule

bind rotr_unit rotr_unit_chk #(.XLEN(XLEN)) chk (.*);

// File: tb/rotr_unit_test.sv
`timescale 1ns/1ps
module rotr_unit_test;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [31:0] instr  = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic        rot_valid, wr_en;
  logic [4:0]  dst_idx;
  logic [63:0] result;

  rotr_unit uut (.instr(instr), .rs_val(rs_val), .rt_val(rt_val),
                 .rot_valid(rot_valid), .wr_en(wr_en), .dst_idx(dst_idx), .result(result));

  typedef struct packed {
    logic [31:0] ins;
    logic [63:0] a;
    logic [63:0] b;
    logic        v;
    logic        w;
    logic [4:0]  d;
    logic [63:0] r;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] A = 64'hFEDC_BA98_1234_5678;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 32-bit immediate rotate by 8
    '{{6'd0,5'd1,5'd2,5'd3,5'd8,6'b000010},  64'd0, A, 1'b1,1'b1,5'd3, 64'h0000_0000_7812_3456, 8'd1},
    // R6 top bit set after rotate by 4
    '{{6'd0,5'd1,5'd2,5'd4,5'd4,6'b000010},  64'd0, A, 1'b1,1'b1,5'd4, 64'hFFFF_FFFF_8123_4567, 8'd6},
    // R2 register amount, upper bits set, low5=8
    '{{6'd0,5'd7,5'd2,5'd5,5'd1,6'b000110},  64'hFFFF_FFFF_FFFF_FFE8, A, 1'b1,1'b1,5'd5, 64'h0000_0000_7812_3456, 8'd2},
    // R2 amount 31
    '{{6'd0,5'd7,5'd2,5'd6,5'd1,6'b000110},  64'h0000_0000_0000_001F, A, 1'b1,1'b1,5'd6, 64'h0000_0000_2468_ACF0, 8'd2},
    // R3 64-bit immediate by 16
    '{{6'd0,5'd1,5'd2,5'd7,5'd16,6'b111010}, 64'd0, A, 1'b1,1'b1,5'd7, 64'h5678_FEDC_BA98_1234, 8'd3},
    // R4 plus-32 with 0
    '{{6'd0,5'd1,5'd2,5'd8,5'd0,6'b111110},  64'd0, A, 1'b1,1'b1,5'd8, 64'h1234_5678_FEDC_BA98, 8'd4},
    // R4 plus-32 with 4
    '{{6'd0,5'd1,5'd2,5'd9,5'd4,6'b111110},  64'd0, A, 1'b1,1'b1,5'd9, 64'h8123_4567_8FED_CBA9, 8'd4},
    // R4 plus-32 with 31
    '{{6'd0,5'd1,5'd2,5'd10,5'd31,6'b111110}, 64'd0, A, 1'b1,1'b1,5'd10, 64'hFDB9_7530_2468_ACF1, 8'd4},
    // R5 register amount 0x48 -> 8
    '{{6'd0,5'd9,5'd2,5'd11,5'd1,6'b010110}, 64'h48, A, 1'b1,1'b1,5'd11, 64'h78FE_DCBA_9812_3456, 8'd5},
    // R7 register amount 0x40 -> 0
    '{{6'd0,5'd9,5'd2,5'd12,5'd1,6'b010110}, 64'h40, A, 1'b1,1'b1,5'd12, A, 8'd7},
    // R7 32-bit zero amount, garbage upper half
    '{{6'd0,5'd1,5'd2,5'd13,5'd0,6'b000010}, 64'd0, 64'h1111_1111_8765_4321, 1'b1,1'b1,5'd13, 64'hFFFF_FFFF_8765_4321, 8'd7},
    // R8 plain logical shift (marker 00000)
    '{{6'd0,5'd0,5'd2,5'd3,5'd8,6'b000010},  64'd0, A, 1'b0,1'b0,5'd3, 64'd0, 8'd8},
    // R8 variable form, marker 00010
    '{{6'd0,5'd7,5'd2,5'd5,5'd2,6'b000110},  64'h8, A, 1'b0,1'b0,5'd5, 64'd0, 8'd8},
    // R8 64-bit form, marker 00011
    '{{6'd0,5'd3,5'd2,5'd7,5'd16,6'b111010}, 64'd0, A, 1'b0,1'b0,5'd7, 64'd0, 8'd8},
    // R9 nonzero opcode
    '{{6'd1,5'd1,5'd2,5'd3,5'd8,6'b000010},  64'd0, A, 1'b0,1'b0,5'd3, 64'd0, 8'd9},
    // R9 arithmetic-shift function code
    '{{6'd0,5'd1,5'd2,5'd3,5'd8,6'b000011},  64'd0, A, 1'b0,1'b0,5'd3, 64'd0, 8'd9},
    // R10 destination zero
    '{{6'd0,5'd1,5'd2,5'd0,5'd8,6'b000010},  64'd0, A, 1'b1,1'b0,5'd0, 64'h0000_0000_7812_3456, 8'd10},
    // R3 64-bit immediate zero amount
    '{{6'd0,5'd1,5'd2,5'd14,5'd0,6'b111010}, 64'd0, A, 1'b1,1'b1,5'd14, A, 8'd3}
  };

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input int req, input logic v, input logic w,
                       input logic [4:0] d, input logic [63:0] r);
    total++;
    if (rot_valid !== v || wr_en !== w || dst_idx !== d || result !== r) begin
      bad++;
      $display("FAIL R%0d: got v=%b w=%b d=%0d r=%h, expected v=%b w=%b d=%0d r=%h",
               req, rot_valid, wr_en, dst_idx, result, v, w, d, r);
    end
  endtask

  task automatic drive(input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    instr = i; rs_val = a; rt_val = b;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(9, 1'b0, 1'b0, 5'd0, 64'd0);   // R9 all-zero word during reset
    rst_n = 1;
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].ins, VECS[k].a, VECS[k].b);
      check(int'(VECS[k].req), VECS[k].v, VECS[k].w, VECS[k].d, VECS[k].r);
    end
    // R6 same low half, different upper half, same answer
    drive({6'd0,5'd1,5'd2,5'd3,5'd8,6'b000010}, 64'd0, 64'h0000_0000_1234_5678);
    check(6, 1'b1, 1'b1, 5'd3, 64'h0000_0000_7812_3456);
    // R2 mask: bit 5 set must not matter in the 32-bit form
    drive({6'd0,5'd7,5'd2,5'd5,5'd1,6'b000110}, 64'h28, A);
    check(2, 1'b1, 1'b1, 5'd5, 64'h0000_0000_7812_3456);
    // R5 mask: bits above 5 ignored, amount 63
    drive({6'd0,5'd9,5'd2,5'd11,5'd1,6'b010110}, 64'hFFFF_FFFF_FFFF_FFFF, A);
    check(5, 1'b1, 1'b1, 5'd11, 64'hFDB9_7530_2468_ACF1);
    // R1 destination 31
    drive({6'd0,5'd1,5'd2,5'd31,5'd16,6'b000010}, 64'd0, A);
    check(1, 1'b1, 1'b1, 5'd31, 64'h0000_0000_5678_1234);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule